// File: doc/BRIEF.md
# Bus Cycle Wait-State Sequencer

This block runs a single external bus access for a processor bus controller. Every access passes through one address state (T1), a number of wait states (Tw), and one data state (T2), then returns to idle. Five chip-select spaces each have their own programmed wait count. The sequencer derives the count for the space being accessed from a set of short-wait and long-wait configuration fields. Spaces 2 and 3 share one long-wait field. Space 4 takes its short-wait field from its own input.

An active-low external WAIT input can lengthen the access. It takes effect only when the access has a non-zero programmed wait count and the mask bit for that space is clear. WAIT is sampled on the falling clock edge inside the final programmed Tw, and only there. An assertion during T1 or during any earlier Tw does nothing. If the sampled value is low, one more Tw follows and WAIT is sampled again in that Tw, until WAIT is seen high.

The space index and every configuration field are captured when the access is accepted. They stay fixed until the access ends.

Top module: `bus_wait_sequencer`

## Requirements
- R1: While reset is asserted, and in the first cycle after reset is released, `state_o` is 0, `cs_no` is all ones and `done_o` is 0. A reset asserted in the middle of an access returns the block to this state.
- R2: A request sampled while idle with a space index 0 to 4 makes `state_o` show T1 in the following cycle. T1 lasts exactly one cycle. Requests are not looked at outside idle.
- R3: The programmed wait count comes from a 2-bit short field `s` and a 3-bit long field `l`:
  - if `s` is 0, 1 or 2, the count is `s`;
  - if `s` is 3 and `l` is below 4, the count is 3+`l`;
  - otherwise the count is 2·`l`.
  The count therefore ranges from 0 to 14.
- R4: Short fields for spaces 0 to 3 sit in `sw_main_i` at bits [2n+1:2n]. The short field for space 4 is `sw_last_i`. The long-field slots in `lw_i` are 3 bits each:
  - slot 0 (bits [2:0]) serves space 0;
  - slot 1 serves space 1;
  - slot 2 serves both spaces 2 and 3;
  - slot 3 (bits [11:9]) serves space 4.
- R5: An access with programmed count N and no effective external wait shows exactly N Tw cycles and then one T2 cycle before idle, for a total length of N+2 cycles.
- R6: When N>0 and `mask_i[space]` is 0, WAIT is sampled on the falling edge within the last programmed Tw. A low sample inserts one more Tw, and sampling repeats in each inserted Tw until a high sample lets the access move to T2. When N is 0 or the mask bit is 1, WAIT has no effect.
- R7: WAIT held low only during T1 and Tw cycles before the last programmed Tw leaves the access length at N+2.
- R8: `cs_no` drives the bit of the captured space low, and only that bit, in every cycle from T1 through T2. All bits are high while idle.
- R9: `done_o` is high in the T2 cycle only. The cycle after T2 is idle.
- R10: Changing the space index, configuration fields or mask after the access is accepted does not change its length or its chip-select.
- R11: A request with a space index of 5, 6 or 7 is ignored: the block stays idle and `cs_no` stays all ones.
- R12: The `state_o` encoding is: idle = 0, T1 = 1, Tw = 2, T2 = 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, sampled while idle |
| space_i | input | 3 | Chip-select space index of the request |
| sw_main_i | input | 8 | Short-wait fields for spaces 0 to 3 |
| sw_last_i | input | 2 | Short-wait field for space 4 |
| lw_i | input | 12 | Four long-wait slots, 3 bits each |
| mask_i | input | 5 | Per-space external-wait mask, 1 = ignore WAIT |
| wait_ni | input | 1 | External WAIT, active low |
| state_o | output | 2 | Current bus state (idle, T1, Tw, T2) |
| cs_no | output | 5 | Active-low chip-selects, one per space |
| done_o | output | 1 | High during the T2 cycle |

## Verification
Two things fall in the same cycle: the programmed wait counter reaching its last Tw, and the external WAIT sample deciding whether T2 follows. The bench provokes this overlap by holding WAIT low for a chosen number of cycles from T1. It uses hold lengths shorter than, equal to and longer than the programmed count. Each case is judged on the measured access length. That length must stay at N+2 whenever the low period ends at or before the last programmed Tw. Otherwise it grows by exactly the number of low samples taken from that Tw onward. The same hold patterns are repeated with the space masked and with a zero count to show that WAIT is then ignored.

// File: rtl/bws_pkg.sv
`timescale 1ns/1ps
package bws_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_T1   = 2'd1,
      ST_TW   = 2'd2,
      ST_T2   = 2'd3
   } bus_state_e;
endpackage

// File: rtl/bws_cfg_select.sv
`timescale 1ns/1ps
// Derives the programmed wait count and external-wait enable for the requested space.
module bws_cfg_select #(
   parameter int NUM_SPACES = 5,
   parameter int SW_W       = 2,
   parameter int LW_W       = 3,
   parameter int CNT_W      = 4,
   parameter int SHARE_LO   = 2,
   localparam int IDX_W     = $clog2(NUM_SPACES),
   localparam int LW_SLOTS  = NUM_SPACES - 1
) (
   input  logic [IDX_W-1:0]                 space_i,
   input  logic [(NUM_SPACES-1)*SW_W-1:0]   sw_main_i,
   input  logic [SW_W-1:0]                  sw_last_i,
   input  logic [LW_SLOTS*LW_W-1:0]         lw_i,
   input  logic [NUM_SPACES-1:0]            mask_i,
   output logic                             valid_o,
   output logic [CNT_W-1:0]                 count_o,
   output logic                             ext_en_o
);
   localparam logic [SW_W-1:0] SW_ESC  = '1;
   localparam logic [LW_W-1:0] LW_HALF = LW_W'(1 << (LW_W - 1));

   if (2 * ((1 << LW_W) - 1) >= (1 << CNT_W)) begin : g_bad_cnt
      $error("CNT_W too narrow for the longest wait count");
   end
   if (SHARE_LO + 1 >= NUM_SPACES) begin : g_bad_share
      $error("shared long-wait pair must lie below the last space");
   end

   logic [CNT_W-1:0] cnt_tab [NUM_SPACES];

   for (genvar s = 0; s < NUM_SPACES; s++) begin : g_space
      localparam int SLOT = (s <= SHARE_LO) ? s : s - 1;
      logic [SW_W-1:0] sw;
      logic [LW_W-1:0] lw;
      if (s == NUM_SPACES - 1) begin : g_last
         assign sw = sw_last_i;
      end else begin : g_main
         assign sw = sw_main_i[s*SW_W +: SW_W];
      end
      assign lw = lw_i[SLOT*LW_W +: LW_W];
      assign cnt_tab[s] = (sw != SW_ESC) ? CNT_W'(sw) :
                          (lw < LW_HALF) ? CNT_W'(SW_ESC) + CNT_W'(lw) :
                                           CNT_W'(lw) << 1;
   end

   assign valid_o = {1'b0, space_i} < (IDX_W + 1)'(NUM_SPACES);

   always_comb begin
      count_o  = '0;
      ext_en_o = 1'b0;
      for (int s = 0; s < NUM_SPACES; s++) begin
         if (space_i == IDX_W'(s)) begin
            count_o  = cnt_tab[s];
            ext_en_o = (cnt_tab[s] != '0) && !mask_i[s];
         end
      end
   end
endmodule

// File: rtl/bws_wait_sampler.sv
`timescale 1ns/1ps
// Captures the external WAIT line; the edge used is chosen by a parameter.
module bws_wait_sampler #(
   parameter bit FALL_EDGE = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic wait_ni,
   output logic wait_seen_o
);
   logic smp_n;

   if (FALL_EDGE) begin : g_fall
      always_ff @(negedge clk_i or negedge rst_ni) begin
         if (!rst_ni) smp_n <= 1'b1;
         else         smp_n <= wait_ni;
      end
   end else begin : g_rise
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) smp_n <= 1'b1;
         else         smp_n <= wait_ni;
      end
   end

   assign wait_seen_o = ~smp_n;
endmodule

// File: rtl/bws_fsm.sv
`timescale 1ns/1ps
// T1 / Tw / T2 sequencing with captured count, space and external-wait enable.
module bws_fsm
   import bws_pkg::*;
#(
   parameter int NUM_SPACES = 5,
   parameter int CNT_W      = 4,
   localparam int IDX_W     = $clog2(NUM_SPACES)
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  req_i,
   input  logic                  valid_i,
   input  logic [IDX_W-1:0]      space_i,
   input  logic [CNT_W-1:0]      count_i,
   input  logic                  ext_en_i,
   input  logic                  wait_seen_i,
   output logic [1:0]            state_o,
   output logic [NUM_SPACES-1:0] cs_no,
   output logic                  done_o
);
   bus_state_e       state_q;
   logic [CNT_W-1:0] rem_q;
   logic             ext_q;
   logic [IDX_W-1:0] space_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         rem_q   <= '0;
         ext_q   <= 1'b0;
         space_q <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (req_i && valid_i) begin
               state_q <= ST_T1;
               rem_q   <= count_i;
               ext_q   <= ext_en_i;
               space_q <= space_i;
            end
            ST_T1: state_q <= (rem_q == '0) ? ST_T2 : ST_TW;
            ST_TW: begin
               if (rem_q > CNT_W'(1))          rem_q   <= rem_q - CNT_W'(1);
               else if (!(ext_q && wait_seen_i)) state_q <= ST_T2;
            end
            ST_T2: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      cs_no = '1;
      for (int s = 0; s < NUM_SPACES; s++) begin
         if (state_q != ST_IDLE && space_q == IDX_W'(s)) cs_no[s] = 1'b0;
      end
   end

   assign state_o = state_q;
   assign done_o  = (state_q == ST_T2);
endmodule

// File: rtl/bus_wait_sequencer.sv
`timescale 1ns/1ps
module bus_wait_sequencer #(
   parameter int NUM_SPACES = 5,
   parameter int SW_W       = 2,
   parameter int LW_W       = 3,
   parameter int CNT_W      = 4,
   parameter int SHARE_LO   = 2,
   parameter bit FALL_EDGE  = 1'b1,
   localparam int IDX_W     = $clog2(NUM_SPACES)
) (
   input  logic                           clk_i,
   input  logic                           rst_ni,
   input  logic                           req_i,
   input  logic [IDX_W-1:0]               space_i,
   input  logic [(NUM_SPACES-1)*SW_W-1:0] sw_main_i,
   input  logic [SW_W-1:0]                sw_last_i,
   input  logic [(NUM_SPACES-1)*LW_W-1:0] lw_i,
   input  logic [NUM_SPACES-1:0]          mask_i,
   input  logic                           wait_ni,
   output logic [1:0]                     state_o,
   output logic [NUM_SPACES-1:0]          cs_no,
   output logic                           done_o
);
   logic             valid;
   logic [CNT_W-1:0] count;
   logic             ext_en;
   logic             wait_seen;

   bws_cfg_select #(
      .NUM_SPACES(NUM_SPACES), .SW_W(SW_W), .LW_W(LW_W),
      .CNT_W(CNT_W), .SHARE_LO(SHARE_LO)
   ) u_cfg (
      .space_i  (space_i),
      .sw_main_i(sw_main_i),
      .sw_last_i(sw_last_i),
      .lw_i     (lw_i),
      .mask_i   (mask_i),
      .valid_o  (valid),
      .count_o  (count),
      .ext_en_o (ext_en)
   );

   bws_wait_sampler #(.FALL_EDGE(FALL_EDGE)) u_smp (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wait_ni    (wait_ni),
      .wait_seen_o(wait_seen)
   );

   bws_fsm #(.NUM_SPACES(NUM_SPACES), .CNT_W(CNT_W)) u_fsm (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .req_i      (req_i),
      .valid_i    (valid),
      .space_i    (space_i),
      .count_i    (count),
      .ext_en_i   (ext_en),
      .wait_seen_i(wait_seen),
      .state_o    (state_o),
      .cs_no      (cs_no),
      .done_o     (done_o)
   );
endmodule

// File: rtl/bws_checker.sv
`timescale 1ns/1ps
module bws_checker #(
   parameter int NUM_SPACES = 5,
   localparam int IDX_W     = $clog2(NUM_SPACES)
) (
   input logic                  clk_i,
   input logic                  rst_ni,
   input logic                  req_i,
   input logic [IDX_W-1:0]      space_i,
   input logic [1:0]            state_o,
   input logic [NUM_SPACES-1:0] cs_no,
   input logic                  done_o
);
   // R8: no chip-select while idle
   p_idle_cs_high_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_o == 2'd0) |-> (cs_no == '1));

   // R8: exactly one chip-select while busy
   p_busy_one_cs_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_o != 2'd0) |-> ($countones(~cs_no) == 1));

   // R10: chip-select held for the whole access
   p_cs_held_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_o != 2'd0 && $past(state_o) != 2'd0) |-> $stable(cs_no));

   // R2: a single T1 cycle
   p_single_t1_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_o == 2'd1) |=> (state_o != 2'd1));

   // R9: idle follows T2
   p_t2_to_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_o == 2'd3) |=> (state_o == 2'd0));

   // R9: done only rises coming out of T1 or Tw
   p_done_entry_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(done_o) |-> ($past(state_o) == 2'd1 || $past(state_o) == 2'd2));

   // R11: out-of-range space ignored
   p_bad_space_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_o == 2'd0 && req_i && {1'b0, space_i} >= (IDX_W + 1)'(NUM_SPACES))
      |=> (state_o == 2'd0));
endmodule

bind bus_wait_sequencer bws_checker #(.NUM_SPACES(NUM_SPACES)) u_chk (
   .clk_i  (clk_i),
   .rst_ni (rst_ni),
   .req_i  (req_i),
   .space_i(space_i),
   .state_o(state_o),
   .cs_no  (cs_no),
   .done_o (done_o)
);

// File: tb/bus_wait_sequencer_tb.sv
`timescale 1ns/1ps
module bus_wait_sequencer_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0;
   logic [2:0]  space = '0;
   logic [7:0]  swm = '0;
   logic [1:0]  swl = '0;
   logic [11:0] lw = '0;
   logic [4:0]  mask = '0;
   logic        wait_n = 1'b1;
   logic [1:0]  state;
   logic [4:0]  cs_n;
   logic        done;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   bus_wait_sequencer u_dut (
      .clk_i(clk), .rst_ni(rst_n), .req_i(req), .space_i(space),
      .sw_main_i(swm), .sw_last_i(swl), .lw_i(lw), .mask_i(mask),
      .wait_ni(wait_n), .state_o(state), .cs_no(cs_n), .done_o(done)
   );

   typedef struct packed {
      logic [2:0]  sp;
      logic [7:0]  swm;
      logic [1:0]  swl;
      logic [11:0] lw;
      logic [4:0]  mask;
      logic [7:0]  k;     // cycles WAIT held low, counted from T1
      logic [7:0]  len;   // expected cycles from T1 through T2
      logic [7:0]  rq;    // requirement tag number
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VECS [NV] = '{
      '{3'd0, 8'h00, 2'd0, 12'h000, 5'h00, 8'd3,  8'd2,  8'd6}, // R6 count 0: WAIT ignored
      '{3'd0, 8'h02, 2'd0, 12'h000, 5'h00, 8'd0,  8'd4,  8'd5}, // R5 count 2
      '{3'd1, 8'h04, 2'd0, 12'h000, 5'h00, 8'd0,  8'd3,  8'd5}, // R5 count 1
      '{3'd1, 8'h04, 2'd0, 12'h000, 5'h1D, 8'd3,  8'd5,  8'd6}, // R6 two extra Tw
      '{3'd2, 8'h30, 2'd0, 12'h140, 5'h00, 8'd0,  8'd12, 8'd3}, // R3 long 5 -> 10
      '{3'd3, 8'hC0, 2'd0, 12'h080, 5'h00, 8'd5,  8'd7,  8'd7}, // R7 low only before last Tw
      '{3'd3, 8'hC0, 2'd0, 12'h080, 5'h00, 8'd8,  8'd10, 8'd6}, // R6 three extra Tw
      '{3'd4, 8'h00, 2'd3, 12'hE00, 5'h00, 8'd0,  8'd16, 8'd3}, // R3 maximum 14
      '{3'd4, 8'h00, 2'd3, 12'hE00, 5'h10, 8'd20, 8'd16, 8'd6}, // R6 masked
      '{3'd0, 8'h03, 2'd0, 12'h003, 5'h00, 8'd7,  8'd9,  8'd6}, // R6 one extra Tw
      '{3'd4, 8'hFF, 2'd1, 12'h000, 5'h00, 8'd0,  8'd3,  8'd4}, // R4 space 4 own short field
      '{3'd2, 8'h30, 2'd0, 12'h038, 5'h00, 8'd0,  8'd5,  8'd4}  // R4 shared slot 2 used
   };

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic run_access(input vec_t v, input bit scramble);
      int idx;
      logic [4:0] exp_cs;
      string tag;
      tag = $sformatf("R%0d", v.rq);
      exp_cs = ~(5'b1 << v.sp);
      @(posedge clk); #1;
      swm = v.swm; swl = v.swl; lw = v.lw; mask = v.mask; space = v.sp;
      wait_n = 1'b1; req = 1'b1;
      @(posedge clk); #1;
      req = 1'b0;
      check(state == 2'd1, "R2 R12 T1 entry", int'(state), 1);
      check(cs_n == exp_cs, "R8 cs in T1", int'(cs_n), int'(exp_cs));
      if (scramble) begin
         swm = 8'hFF; swl = 2'b11; lw = 12'hFFF; mask = 5'h00; space = 3'd4;
      end
      idx = 0;
      wait_n = (v.k > 0) ? 1'b0 : 1'b1;
      while (state != 2'd3 && idx < 60) begin
         @(posedge clk); #1;
         idx++;
         wait_n = (idx < int'(v.k)) ? 1'b0 : 1'b1;
      end
      check(idx + 1 == int'(v.len), scramble ? "R10 length" : tag, idx + 1, int'(v.len));
      check(done == 1'b1, "R9 done in T2", int'(done), 1);
      check(cs_n == exp_cs, scramble ? "R10 cs" : "R8 cs in T2", int'(cs_n), int'(exp_cs));
      @(posedge clk); #1;
      wait_n = 1'b1;
      check(state == 2'd0 && done == 1'b0 && cs_n == 5'h1F, "R9 idle after T2",
            int'({state, done, cs_n}), int'({2'd0, 1'b0, 5'h1F}));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #3;
      check(state == 2'd0 && cs_n == 5'h1F && done == 1'b0, "R1 in reset",
            int'({state, done, cs_n}), int'({2'd0, 1'b0, 5'h1F}));
      repeat (2) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk); #1;
      check(state == 2'd0 && cs_n == 5'h1F && done == 1'b0, "R1 after release",
            int'({state, done, cs_n}), int'({2'd0, 1'b0, 5'h1F}));

      for (int i = 0; i < NV; i++) run_access(VECS[i], 1'b0);

      // R10: captured configuration survives changes mid-access
      run_access('{3'd0, 8'h02, 2'd0, 12'h000, 5'h00, 8'd0, 8'd4, 8'd10}, 1'b1);

      // R11: out-of-range spaces ignored
      for (int s = 5; s < 8; s++) begin
         @(posedge clk); #1;
         space = 3'(s); swm = 8'hFF; req = 1'b1;
         @(posedge clk); #1;
         check(state == 2'd0, "R11 stays idle", int'(state), 0);
         check(cs_n == 5'h1F, "R11 no chip-select", int'(cs_n), 31);
         req = 1'b0;
      end

      // R2: request held through a busy access starts nothing extra inside it
      @(posedge clk); #1;
      space = 3'd1; swm = 8'h04; mask = 5'h00; req = 1'b1;
      @(posedge clk); #1;
      check(state == 2'd1, "R2 held req T1", int'(state), 1);
      @(posedge clk); #1;
      check(state == 2'd2, "R2 held req Tw", int'(state), 2);
      @(posedge clk); #1;
      check(state == 2'd3, "R2 held req T2", int'(state), 3);
      req = 1'b0;
      @(posedge clk); #1;
      check(state == 2'd0, "R2 back to idle", int'(state), 0);

      // R1: reset in the middle of an access
      @(posedge clk); #1;
      space = 3'd2; swm = 8'h30; lw = 12'h140; req = 1'b1;
      @(posedge clk); #1;
      req = 1'b0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b0;
      #1;
      check(state == 2'd0 && cs_n == 5'h1F && done == 1'b0, "R1 mid-access reset",
            int'({state, done, cs_n}), int'({2'd0, 1'b0, 5'h1F}));
      @(posedge clk); #1 rst_n = 1'b1;
      @(posedge clk); #1;
      check(state == 2'd0, "R1 idle after reset", int'(state), 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule